// File: doc/BRIEF.md
# I2C Message Sequencer

This block carries out a single I2C message on its own, in place of an interrupt routine. It drives a register-mapped byte-level I2C master core. Each time the core raises its interrupt flag, the sequencer reads the core's 8-bit status code and decides what to do next. It can send a START, load an address or data byte into the core's data register, let the core continue, or end the message with STOP. Every one of these actions finishes with a write to the core's control register, and that control write is what clears the core's flag.

A message is given as a descriptor with these fields:
- a 10-bit address
- a flag that selects 10-bit addressing
- the transfer direction
- a flag that skips the START and address phases (continuing a transfer already on the bus)
- a byte count

Write bytes arrive on a valid/ready stream. Read bytes leave on a second valid/ready stream. When the message ends, the block pulses `done` for one clock and presents a 2-bit result code. The `abort_req` input asks the sequencer to wind the message down early and cleanly.

Top module: `i2c_msg_seq`

## Requirements
- R1: With 7-bit addressing, the first address byte is `{addr[6:0], dir}`, where dir is 1 for a read. This byte is written to the data register when the status is 0x08 or 0x10.
- R2: With 10-bit addressing, the first address byte is `{5'b11110, addr[9:8], dir}`. On status 0x18 (write) or 0x40 (read), the second byte `addr[7:0]` is written next.
- R3: The control word has these bit positions: [0] core enable (always 1), [1] interrupt enable, [2] ACK, [3] START, [4] STOP. Accepting a normal descriptor writes the control word with START set. Every data-register write comes with a control write in the same cycle.
- R4: On status 0x18 (7-bit), 0xD0 or 0x28, the next byte from the write stream is sent while any bytes remain. When no bytes remain, the sequencer issues STOP and finishes with result OK (0).
- R5: On status 0x40 (7-bit) or 0xE0, a zero-length read issues STOP and finishes with result OK. Otherwise the sequencer continues, with ACK=1 unless only one byte remains. On each status 0x50, `core_rdata` goes out on the read stream, and ACK is cleared once one byte is left.
- R6: Status 0x58 sends the final received byte out on the read stream, issues STOP and finishes.
- R7: Statuses 0x20, 0x30 and 0x48 issue STOP and finish with result no-device (1).
- R8: Any status not listed above issues STOP, pulses `core_rst` for one cycle together with that STOP, and finishes with result I/O error (2).
- R9: While an abort is pending:
  - a write that has already sent at least one byte stops at its next ACK status, with result aborted (3);
  - a write that has sent nothing still sends its first byte;
  - reads clear ACK.
- R10: In no-start mode, a read writes only a continue control word (no START), and clears ACK if the length is 1. A write sends its first byte when the descriptor is accepted.
- R11: If the flag rises while no message is active, the sequencer answers with STOP only. It does not pulse `done`.
- R12: Every STOP control word has interrupt enable cleared. `done` is a single-cycle pulse that comes with the finishing STOP. Control writes are never issued on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Descriptor valid |
| cmd_ready | output | 1 | Descriptor accepted while high with cmd_valid |
| cmd_addr | input | 10 | Target address |
| cmd_ten | input | 1 | 10-bit addressing |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_nostart | input | 1 | Skip START and address phases |
| cmd_len | input | LEN_W | Byte count |
| abort_req | input | 1 | Request early termination |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte consumed |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read sink can take a byte |
| rd_data | output | 8 | Read byte |
| core_flag | input | 1 | Core interrupt flag |
| core_status | input | 8 | Core status code |
| core_rdata | input | 8 | Core data register (received byte) |
| ctl_we | output | 1 | Control register write strobe |
| ctl_wdata | output | 5 | Control word |
| dat_we | output | 1 | Data register write strobe |
| dat_wdata | output | 8 | Data register value |
| core_rst | output | 1 | Core soft-reset pulse |
| done | output | 1 | Message finished (one clock) |
| result | output | 2 | 0 OK, 1 no device, 2 I/O error, 3 aborted |

## Verification
A wrong internal state shows up in the first control or data-register write after the status that exposes it. That write appears at the ports one cycle after the flag is seen. Such faults include a miscounted remaining length, a stale abort or sent-byte marker, or a wrong phase. They cause one of three visible effects:
- a STOP one status too early or too late;
- an ACK bit that flips at the wrong byte;
- a wrong result code on the `done` pulse.

The directed scenarios walk each status path and compare every control word, data byte, stream byte and result against values derived from the requirements.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

   typedef enum logic [2:0] {
      S_IDLE, S_START, S_ADR1, S_ADR2, S_TXACK, S_RXDAT
   } seq_st_e;

   typedef enum logic [3:0] {
      A_NONE, A_CONT, A_START, A_ADR1, A_ADR2,
      A_SEND, A_RECV, A_RECV_STOP, A_STOP, A_FAULT
   } act_e;

   typedef enum logic [1:0] {
      RES_OK, RES_NODEV, RES_IOERR, RES_ABORT
   } res_e;

   localparam int CW     = 5;
   localparam int CB_EN  = 0;
   localparam int CB_IEN = 1;
   localparam int CB_ACK = 2;
   localparam int CB_STA = 3;
   localparam int CB_STO = 4;

   localparam logic [7:0] ST_START    = 8'h08;
   localparam logic [7:0] ST_RSTART   = 8'h10;
   localparam logic [7:0] ST_WA_ACK   = 8'h18;
   localparam logic [7:0] ST_WA_NACK  = 8'h20;
   localparam logic [7:0] ST_WD_ACK   = 8'h28;
   localparam logic [7:0] ST_WD_NACK  = 8'h30;
   localparam logic [7:0] ST_RA_ACK   = 8'h40;
   localparam logic [7:0] ST_RA_NACK  = 8'h48;
   localparam logic [7:0] ST_RD_ACK   = 8'h50;
   localparam logic [7:0] ST_RD_NACK  = 8'h58;
   localparam logic [7:0] ST_WA2_ACK  = 8'hD0;
   localparam logic [7:0] ST_RA2_ACK  = 8'hE0;

endpackage

// File: rtl/i2cseq_addr.sv
module i2cseq_addr (
   input  logic [9:0] addr,
   input  logic       ten,
   input  logic       rd,
   output logic [7:0] byte1,
   output logic [7:0] byte2
);
   always_comb begin
      if (ten) begin
         byte1 = {5'b11110, addr[9:8], rd};
         byte2 = addr[7:0];
      end else begin
         byte1 = {addr[6:0], rd};
         byte2 = 8'h00;
      end
   end
endmodule

// File: rtl/i2cseq_decode.sv
module i2cseq_decode
   import i2cseq_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  seq_st_e          state,
   input  logic [7:0]       status,
   input  logic             ten,
   input  logic [LEN_W-1:0] left,
   input  logic             sent_any,
   input  logic             aborting,
   output act_e             act,
   output seq_st_e          nxt,
   output logic             dec_left,
   output logic             clr_ack,
   output res_e             res
);
   localparam logic [LEN_W-1:0] L_ZERO = '0;
   localparam logic [LEN_W-1:0] L_ONE  = LEN_W'(1);

   logic [LEN_W-1:0] left_m1;
   res_e             fin_res;

   assign left_m1 = left - L_ONE;
   assign fin_res = aborting ? RES_ABORT : RES_OK;

   always_comb begin
      act      = A_FAULT;
      nxt      = S_IDLE;
      dec_left = 1'b0;
      clr_ack  = 1'b0;
      res      = RES_IOERR;
      if (state == S_IDLE) begin
         act = A_STOP;
         res = RES_OK;
      end else begin
         unique case (status)
            ST_START, ST_RSTART: begin
               act = A_ADR1;
               nxt = S_ADR1;
            end
            ST_WA_ACK, ST_WA2_ACK, ST_WD_ACK: begin
               if (status == ST_WA_ACK && ten) begin
                  act = A_ADR2;
                  nxt = S_ADR2;
               end else if (left == L_ZERO || (aborting && sent_any)) begin
                  act = A_STOP;
                  res = fin_res;
               end else begin
                  act      = A_SEND;
                  nxt      = S_TXACK;
                  dec_left = 1'b1;
               end
            end
            ST_RA_ACK, ST_RA2_ACK: begin
               if (status == ST_RA_ACK && ten) begin
                  act = A_ADR2;
                  nxt = S_ADR2;
               end else if (left == L_ZERO) begin
                  act = A_STOP;
                  res = fin_res;
               end else begin
                  act     = A_CONT;
                  nxt     = S_RXDAT;
                  clr_ack = (left == L_ONE) || aborting;
               end
            end
            ST_RD_ACK: begin
               act      = A_RECV;
               nxt      = S_RXDAT;
               dec_left = 1'b1;
               clr_ack  = (left_m1 == L_ONE) || aborting;
            end
            ST_RD_NACK: begin
               act = A_RECV_STOP;
               res = fin_res;
            end
            ST_WA_NACK, ST_WD_NACK, ST_RA_NACK: begin
               act = A_STOP;
               res = RES_NODEV;
            end
            default: begin
               act = A_FAULT;
               res = RES_IOERR;
            end
         endcase
      end
   end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
   import i2cseq_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [9:0]       cmd_addr,
   input  logic             cmd_ten,
   input  logic             cmd_rd,
   input  logic             cmd_nostart,
   input  logic [LEN_W-1:0] cmd_len,
   input  logic             abort_req,
   input  logic             wr_valid,
   output logic             wr_ready,
   input  logic [7:0]       wr_data,
   output logic             rd_valid,
   input  logic             rd_ready,
   output logic [7:0]       rd_data,
   input  logic             core_flag,
   input  logic [7:0]       core_status,
   input  logic [7:0]       core_rdata,
   output logic             ctl_we,
   output logic [4:0]       ctl_wdata,
   output logic             dat_we,
   output logic [7:0]       dat_wdata,
   output logic             core_rst,
   output logic             done,
   output logic [1:0]       result
);
   localparam logic [LEN_W-1:0] L_ZERO = '0;
   localparam logic [LEN_W-1:0] L_ONE  = LEN_W'(1);

   if (LEN_W < 2) begin : g_len_chk
      $error("i2c_msg_seq: LEN_W must be at least 2");
   end

   seq_st_e          st_q, st_n;
   logic [LEN_W-1:0] left_q, left_n;
   logic             sent_q, sent_n, ack_q, ack_n, abort_q, ten_q;
   logic [7:0]       b1_q, b2_q, b1_c, b2_c, dbyte;
   act_e             dec_act, act;
   seq_st_e          dec_nxt;
   logic             dec_dec, dec_clr;
   res_e             dec_res, res_n;
   logic             abort_eff, react, idle_ok, ns_wr, accept, is_rx, stall;
   logic             fin, dwe_n, stop_n;

   i2cseq_addr u_addr (
      .addr (cmd_addr), .ten (cmd_ten), .rd (cmd_rd),
      .byte1(b1_c),     .byte2(b2_c)
   );

   assign abort_eff = abort_q | abort_req;

   i2cseq_decode #(.LEN_W(LEN_W)) u_dec (
      .state   (st_q),    .status  (core_status), .ten     (ten_q),
      .left    (left_q),  .sent_any(sent_q),      .aborting(abort_eff),
      .act     (dec_act), .nxt     (dec_nxt),     .dec_left(dec_dec),
      .clr_ack (dec_clr), .res     (dec_res)
   );

   // The cycle after a control write the core's flag may still be up.
   assign react     = core_flag && !ctl_we;
   assign idle_ok   = (st_q == S_IDLE) && !core_flag && !ctl_we;
   assign ns_wr     = cmd_nostart && !cmd_rd && (cmd_len != L_ZERO);
   assign cmd_ready = idle_ok && (!ns_wr || wr_valid);
   assign accept    = cmd_valid && cmd_ready;
   assign is_rx     = (dec_act == A_RECV) || (dec_act == A_RECV_STOP);
   assign rd_valid  = react && is_rx;
   assign rd_data   = core_rdata;
   assign wr_ready  = react ? (dec_act == A_SEND) : (idle_ok && cmd_valid && ns_wr);
   assign stall     = ((dec_act == A_SEND) && !wr_valid) || (is_rx && !rd_ready);

   always_comb begin
      act    = A_NONE;
      st_n   = st_q;
      ack_n  = ack_q;
      left_n = left_q;
      sent_n = sent_q;
      res_n  = dec_res;
      fin    = 1'b0;
      if (react && !stall) begin
         act   = dec_act;
         st_n  = dec_nxt;
         ack_n = ack_q & ~dec_clr;
         if (dec_dec) left_n = left_q - L_ONE;
         if (dec_act == A_SEND) sent_n = 1'b1;
         fin = (st_q != S_IDLE) &&
               (dec_act == A_STOP || dec_act == A_RECV_STOP || dec_act == A_FAULT);
      end else if (accept) begin
         left_n = cmd_len;
         sent_n = 1'b0;
         ack_n  = 1'b1;
         res_n  = RES_OK;
         if (!cmd_nostart) begin
            act  = A_START;
            st_n = S_START;
         end else if (cmd_rd) begin
            act   = A_CONT;
            st_n  = S_RXDAT;
            ack_n = (cmd_len != L_ONE);
         end else if (cmd_len == L_ZERO) begin
            act  = A_STOP;
            st_n = S_IDLE;
            fin  = 1'b1;
         end else begin
            act    = A_SEND;
            st_n   = S_TXACK;
            left_n = cmd_len - L_ONE;
            sent_n = 1'b1;
         end
      end
   end

   always_comb begin
      unique case (act)
         A_ADR1:  dbyte = b1_q;
         A_ADR2:  dbyte = b2_q;
         A_SEND:  dbyte = wr_data;
         default: dbyte = 8'h00;
      endcase
   end

   assign dwe_n  = (act == A_ADR1) || (act == A_ADR2) || (act == A_SEND);
   assign stop_n = (act == A_STOP) || (act == A_RECV_STOP) || (act == A_FAULT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         left_q    <= '0;
         sent_q    <= 1'b0;
         ack_q     <= 1'b1;
         abort_q   <= 1'b0;
         ten_q     <= 1'b0;
         b1_q      <= 8'h00;
         b2_q      <= 8'h00;
         ctl_we    <= 1'b0;
         ctl_wdata <= '0;
         dat_we    <= 1'b0;
         dat_wdata <= 8'h00;
         core_rst  <= 1'b0;
         done      <= 1'b0;
         result    <= 2'd0;
      end else begin
         st_q      <= st_n;
         left_q    <= left_n;
         sent_q    <= sent_n;
         ack_q     <= ack_n;
         ctl_we    <= (act != A_NONE);
         ctl_wdata <= {stop_n, act == A_START, ack_n, !stop_n, 1'b1};
         dat_we    <= dwe_n;
         dat_wdata <= dbyte;
         core_rst  <= (act == A_FAULT);
         done      <= fin;
         if (fin) result <= res_n;
         if (accept) begin
            ten_q <= cmd_ten;
            b1_q  <= b1_c;
            b2_q  <= b2_c;
         end
         if (fin || accept)                     abort_q <= 1'b0;
         else if (abort_req && st_q != S_IDLE)  abort_q <= 1'b1;
      end
   end

   // R3
   data_with_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dat_we |-> ctl_we);
   // R3
   start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_wdata[CB_STA]) |-> (st_q == S_START));
   // R12
   stop_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_wdata[CB_STO]) |-> !ctl_wdata[CB_IEN]);
   // R12
   done_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ctl_we && ctl_wdata[CB_STO]));
   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R12
   ctl_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> !ctl_we);
   // R8
   rst_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |-> (done && ctl_wdata[CB_STO] && result == 2'd2));
   // R11
   idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_flag && !ctl_we && st_q == S_IDLE) |=> !done);
endmodule

// File: tb/test_i2c_msg_seq.sv
module test_i2c_msg_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0, cmd_ready;
   logic [9:0] cmd_addr = '0;
   logic       cmd_ten = 1'b0, cmd_rd = 1'b0, cmd_nostart = 1'b0;
   logic [7:0] cmd_len = '0;
   logic       abort_req = 1'b0;
   logic       wr_valid, wr_ready;
   logic [7:0] wr_data;
   logic       rd_valid, rd_ready = 1'b1;
   logic [7:0] rd_data;
   logic       core_flag = 1'b0;
   logic [7:0] core_status = '0, core_rdata = '0;
   logic       ctl_we, dat_we, core_rst, done;
   logic [4:0] ctl_wdata;
   logic [7:0] dat_wdata;
   logic [1:0] result;

   int checks = 0, errors = 0;
   int wr_cnt = 0, wbase = 0, wlen = 0, rd_cnt = 0;
   logic [7:0] wbuf [4];
   logic [7:0] rd_log = '0;
   logic [4:0] s_ctl;
   logic [7:0] s_dat;
   logic       s_dwe, s_done, s_rst;
   logic [1:0] s_res;

   localparam logic [4:0] C_START = 5'b01111;
   localparam logic [4:0] C_RUN   = 5'b00111;
   localparam logic [4:0] C_NACK  = 5'b00011;
   localparam logic [4:0] C_STOPM = 5'b10001; // compared under mask 5'b11011

   always #5 clk = ~clk;

   assign wr_valid = (wr_cnt - wbase) < wlen;
   assign wr_data  = wbuf[2'(wr_cnt - wbase)];

   always @(posedge clk) begin
      if (wr_valid && wr_ready) wr_cnt <= wr_cnt + 1;
      if (rd_valid && rd_ready) begin
         rd_log <= rd_data;
         rd_cnt <= rd_cnt + 1;
      end
   end

   i2c_msg_seq #(.LEN_W(8)) i_i2c_msg_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
      .cmd_ten(cmd_ten), .cmd_rd(cmd_rd), .cmd_nostart(cmd_nostart), .cmd_len(cmd_len),
      .abort_req(abort_req),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
      .core_flag(core_flag), .core_status(core_status), .core_rdata(core_rdata),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .dat_we(dat_we), .dat_wdata(dat_wdata),
      .core_rst(core_rst), .done(done), .result(result)
   );

   task automatic ck(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Called at a negedge; returns at the negedge where the control write shows.
   task automatic wait_ctl(input string tag);
      int n = 0;
      @(negedge clk);
      while (!ctl_we && n < 100) begin
         @(negedge clk);
         n++;
      end
      if (!ctl_we) ck(1'b0, {tag, " no control write"}, 0, 1);
      s_ctl = ctl_wdata; s_dat = dat_wdata; s_dwe = dat_we;
      s_done = done; s_res = result; s_rst = core_rst;
      core_flag = 1'b0;
      cmd_valid = 1'b0;
   endtask

   task automatic step(input logic [7:0] st, input logic [7:0] rdat, input string tag);
      core_status = st;
      core_rdata  = rdat;
      core_flag   = 1'b1;
      wait_ctl(tag);
   endtask

   task automatic cmd(input logic [9:0] a, input logic ten, input logic rd,
                      input logic ns, input logic [7:0] len, input string tag);
      @(negedge clk);
      cmd_addr = a; cmd_ten = ten; cmd_rd = rd; cmd_nostart = ns; cmd_len = len;
      cmd_valid = 1'b1;
      wait_ctl(tag);
   endtask

   task automatic load_wr(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2, input int n);
      wbuf[0] = b0; wbuf[1] = b1; wbuf[2] = b2; wbuf[3] = 8'h00;
      wbase = wr_cnt;
      wlen  = n;
   endtask

   task automatic ck_data(input logic [7:0] exp_dat, input string tag);
      ck(s_dwe === 1'b1, {tag, " dat_we"}, int'(s_dwe), 1);
      ck(s_dat === exp_dat, {tag, " data byte"}, int'(s_dat), int'(exp_dat));
      ck(s_ctl === C_RUN, {tag, " control"}, int'(s_ctl), int'(C_RUN));
   endtask

   task automatic ck_stop(input logic exp_done, input logic [1:0] exp_res, input string tag);
      ck((s_ctl & 5'b11011) === C_STOPM, {tag, " stop word"}, int'(s_ctl), int'(C_STOPM));
      ck(s_dwe === 1'b0, {tag, " no data write"}, int'(s_dwe), 0);
      ck(s_done === exp_done, {tag, " done"}, int'(s_done), int'(exp_done));
      if (exp_done) ck(s_res === exp_res, {tag, " result"}, int'(s_res), int'(exp_res));
   endtask

   task automatic t_reset;
      ck(ctl_we === 1'b0 && dat_we === 1'b0, "R12 reset strobes", int'(ctl_we), 0);
      ck(done === 1'b0 && core_rst === 1'b0, "R12 reset done", int'(done), 0);
      ck(cmd_ready === 1'b1, "R3 reset ready", int'(cmd_ready), 1);
   endtask

   task automatic t_write7;
      load_wr(8'h3C, 8'hA5, 8'h00, 2);
      cmd(10'h050, 1'b0, 1'b0, 1'b0, 8'd2, "R3 start");
      ck(s_ctl === C_START && !s_dwe, "R3 start word", int'(s_ctl), int'(C_START));
      step(8'h08, 8'h00, "R1");       ck_data(8'hA0, "R1 addr7 write");
      step(8'h18, 8'h00, "R4");       ck_data(8'h3C, "R4 byte0");
      step(8'h28, 8'h00, "R4");       ck_data(8'hA5, "R4 byte1");
      step(8'h28, 8'h00, "R4");       ck_stop(1'b1, 2'd0, "R4 end");
      @(negedge clk);
      ck(done === 1'b0, "R12 done one cycle", int'(done), 0);
   endtask

   task automatic t_read7;
      int c0;
      cmd(10'h021, 1'b0, 1'b1, 1'b0, 8'd2, "R1 rd");
      step(8'h10, 8'h00, "R1");       ck_data(8'h43, "R1 addr7 read");
      step(8'h40, 8'h00, "R5");
      ck(s_ctl === C_RUN && !s_dwe, "R5 continue ack", int'(s_ctl), int'(C_RUN));
      c0 = rd_cnt;
      step(8'h50, 8'h11, "R5");
      ck(s_ctl === C_NACK, "R5 ack cleared last", int'(s_ctl), int'(C_NACK));
      ck(rd_log === 8'h11 && rd_cnt == c0 + 1, "R5 byte0 out", int'(rd_log), 'h11);
      step(8'h58, 8'h22, "R6");       ck_stop(1'b1, 2'd0, "R6 end");
      ck(rd_log === 8'h22 && rd_cnt == c0 + 2, "R6 last byte", int'(rd_log), 'h22);
   endtask

   task automatic t_write10;
      load_wr(8'h5E, 8'h00, 8'h00, 1);
      cmd(10'h2A5, 1'b1, 1'b0, 1'b0, 8'd1, "R2");
      step(8'h08, 8'h00, "R2");       ck_data(8'hF4, "R2 first w");
      step(8'h18, 8'h00, "R2");       ck_data(8'hA5, "R2 second w");
      step(8'hD0, 8'h00, "R4");       ck_data(8'h5E, "R4 after addr2");
      step(8'h28, 8'h00, "R4");       ck_stop(1'b1, 2'd0, "R4 10bit end");
   endtask

   task automatic t_read10_zero;
      cmd(10'h1C3, 1'b1, 1'b1, 1'b0, 8'd0, "R2 r");
      step(8'h10, 8'h00, "R2");       ck_data(8'hF3, "R2 first r");
      step(8'h40, 8'h00, "R2");       ck_data(8'hC3, "R2 second r");
      step(8'hE0, 8'h00, "R5");       ck_stop(1'b1, 2'd0, "R5 zero length");
   endtask

   task automatic t_nodev;
      load_wr(8'h01, 8'h00, 8'h00, 1);
      cmd(10'h011, 1'b0, 1'b0, 1'b0, 8'd1, "R7");
      step(8'h08, 8'h00, "R7");
      step(8'h20, 8'h00, "R7");       ck_stop(1'b1, 2'd1, "R7 addr nack");
      cmd(10'h011, 1'b0, 1'b1, 1'b0, 8'd1, "R7 rd");
      step(8'h08, 8'h00, "R7");
      step(8'h48, 8'h00, "R7");       ck_stop(1'b1, 2'd1, "R7 read addr nack");
   endtask

   task automatic t_fault;
      cmd(10'h011, 1'b0, 1'b0, 1'b0, 8'd1, "R8");
      step(8'h08, 8'h00, "R8");
      step(8'h00, 8'h00, "R8");       ck_stop(1'b1, 2'd2, "R8 bus error");
      ck(s_rst === 1'b1, "R8 core reset", int'(s_rst), 1);
      @(negedge clk);
      ck(core_rst === 1'b0, "R8 reset one cycle", int'(core_rst), 0);
   endtask

   task automatic t_abort_wr;
      load_wr(8'h71, 8'h72, 8'h73, 3);
      cmd(10'h033, 1'b0, 1'b0, 1'b0, 8'd3, "R9");
      step(8'h08, 8'h00, "R9");
      abort_req = 1'b1;
      step(8'h18, 8'h00, "R9");       ck_data(8'h71, "R9 first byte still sent");
      step(8'h28, 8'h00, "R9");       ck_stop(1'b1, 2'd3, "R9 write aborted");
      abort_req = 1'b0;
   endtask

   task automatic t_abort_rd;
      cmd(10'h033, 1'b0, 1'b1, 1'b0, 8'd3, "R9 rd");
      step(8'h08, 8'h00, "R9");
      abort_req = 1'b1;
      step(8'h40, 8'h00, "R9");
      ck(s_ctl === C_NACK, "R9 read nack on abort", int'(s_ctl), int'(C_NACK));
      step(8'h58, 8'h5A, "R9");       ck_stop(1'b1, 2'd3, "R9 read aborted");
      abort_req = 1'b0;
   endtask

   task automatic t_nostart;
      cmd(10'h000, 1'b0, 1'b1, 1'b1, 8'd1, "R10 rd");
      ck(s_ctl === C_NACK && !s_dwe, "R10 read continue", int'(s_ctl), int'(C_NACK));
      step(8'h58, 8'h77, "R10");      ck_stop(1'b1, 2'd0, "R10 read end");
      ck(rd_log === 8'h77, "R10 byte", int'(rd_log), 'h77);
      load_wr(8'h9A, 8'h9B, 8'h00, 2);
      cmd(10'h000, 1'b0, 1'b0, 1'b1, 8'd2, "R10 wr");
      ck_data(8'h9A, "R10 immediate byte");
      step(8'h28, 8'h00, "R10");      ck_data(8'h9B, "R10 second byte");
      step(8'h28, 8'h00, "R10");      ck_stop(1'b1, 2'd0, "R10 write end");
   endtask

   task automatic t_idle_flag;
      @(negedge clk);
      step(8'h28, 8'h00, "R11");      ck_stop(1'b0, 2'd0, "R11 idle flag");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_write7;
      t_read7;
      t_write10;
      t_read10_zero;
      t_nodev;
      t_fault;
      t_abort_wr;
      t_abort_rd;
      t_nostart;
      t_idle_flag;
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      checks++;
      errors++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule